// File: doc/BRIEF.md
# Make-Before-Break Digital Crossbar

This block is a digital crossbar with N inputs and M outputs. A matrix of N×M crosspoint enables, one bit for each input/output pair, chooses which input drives each output. Any input can reach any output, and one input may drive any number of outputs at the same time. The data path is purely combinational. An output's lane carries its selected input's word, or zero when nothing selects it. Because each crosspoint is set directly by address, no route search is needed.

A command port with a valid/ready handshake takes three requests:

- **connect**: attaches an input to an idle output.
- **disconnect**: releases an output.
- **move**: takes an output from its present source to a new one without a gap.

A move is done make-before-break. The new crosspoint closes first. Both crosspoints then stay closed for a programmable overlap, during which the output carries the bitwise OR of the two sources. Only after that is the old crosspoint opened. The block shows busy for the whole sequence and pulses done at its end. An illegal request changes nothing and pulses an error flag instead.

Top module: `mbb_xbar`

## Requirements
- R1: While reset is held, and after it is released with no command given, every output lane is 0 whatever the inputs, and busy, done and err are 0.
- R2: Connect (cmd_op = 2'b01) on an idle output closes crosspoint (cmd_out, cmd_in) at the accepting edge. It pulses done for the following cycle without raising busy. One input may be connected to several outputs this way (fan-out).
- R3: Output lane o (bits o*DW up to o*DW+DW-1 of out_data) equals the input lane of its connected source, input lane i being bits i*DW up to i*DW+DW-1 of in_data. A lane with no source reads 0. The path is combinational.
- R4: Disconnect (cmd_op = 2'b10) on an output with a source opens all of that output's crosspoints at the accepting edge, so the lane reads 0 from the next cycle, and pulses done. The input index is not used.
- R5: Move (cmd_op = 2'b11) closes the new crosspoint at the accepting edge while the old one stays closed. For overlap_cycles+1 cycles the lane is the bitwise OR of the old and new input lanes, and busy is high and cmd_ready is low for exactly those cycles.
- R6: When the overlap ends, the old crosspoint opens. In that same cycle busy falls and done pulses for one cycle, and the lane carries only the new input from then on.
- R7: Each of these requests is ignored, leaving every lane unchanged, and pulses err for one cycle without done:
  - cmd_op = 2'b00;
  - cmd_out ≥ N_OUT;
  - cmd_in ≥ N_IN on a connect or move;
  - a connect on an output that already has a source;
  - a disconnect on an output with no source;
  - a move on an output with no source, or to its present source.
- R8: done and err are never high together. Outside a move, no output has more than one closed crosspoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (not busy) |
| cmd_op | input | 2 | 00 none, 01 connect, 10 disconnect, 11 move |
| cmd_out | input | $clog2(N_OUT)+1 | Output index |
| cmd_in | input | $clog2(N_IN)+1 | Input index |
| overlap_cycles | input | OVL_W | Extra overlap cycles for a move, sampled at acceptance |
| in_data | input | N_IN*DW | Input lanes, lane i at bits i*DW |
| out_data | output | N_OUT*DW | Output lanes, lane o at bits o*DW |
| busy | output | 1 | Move sequence in progress |
| done | output | 1 | One-cycle pulse when a legal command completes |
| err | output | 1 | One-cycle pulse when a command is ignored |

## Verification
The assertions rely on a few things about the inputs:
- A command is taken only while cmd_ready is high.
- overlap_cycles and the command fields matter only in the accepting cycle.
- Connect and disconnect commands keep each output at no more than one source, so a move always starts from exactly one closed crosspoint.

The stimulus keeps within these limits:
- Every command is driven on a falling edge, and only after cmd_ready has been seen high.
- The bench releases valid one cycle later.
- Random indices are drawn one value past each legal range, so illegal requests go through the same path, and their error pulse and lack of effect are checked at the lanes.
- Input lanes are redrawn before every sample, so the OR during overlap is checked against fresh data.

// File: rtl/mbb_xbar_pkg.sv
package mbb_xbar_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_CONNECT = 2'b01,
    OP_DROP    = 2'b10,
    OP_MOVE    = 2'b11
  } xbar_op_e;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_OVERLAP = 1'b1
  } xbar_state_e;
endpackage

// File: rtl/mbb_xbar_col.sv
module mbb_xbar_col #(
  parameter int N_IN = 4,
  parameter int DW   = 8
) (
  input  logic [N_IN-1:0]    sel,
  input  logic [N_IN*DW-1:0] in_data,
  output logic [DW-1:0]      y
);
  // Wired overlap: every closed crosspoint contributes its lane to an OR.
  function automatic logic [DW-1:0] or_select(input logic [N_IN-1:0] s,
                                               input logic [N_IN*DW-1:0] d);
    logic [DW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N_IN; i++)
      if (s[i]) acc = acc | d[i*DW +: DW];
    return acc;
  endfunction

  assign y = or_select(sel, in_data);
endmodule

// File: rtl/mbb_xbar_seq.sv
module mbb_xbar_seq
  import mbb_xbar_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int OVL_W = 4,
  parameter int IW    = 3,
  parameter int OW    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [OW-1:0]          cmd_out,
  input  logic [IW-1:0]          cmd_in,
  input  logic [OVL_W-1:0]       overlap_cycles,
  output logic [N_OUT*N_IN-1:0]  xp_flat,
  output logic [N_IN-1:0]        mv_row,
  output logic                   make_ev,
  output logic                   break_ev,
  output logic                   busy,
  output logic                   done,
  output logic                   err
);
  logic [N_OUT-1:0][N_IN-1:0] xp_q;
  xbar_state_e                state_q;
  logic [OVL_W-1:0]           cnt_q;
  logic [OW-1:0]              mv_out_q;
  logic [N_IN-1:0]            mv_new_q;
  logic                       done_q, err_q;

  function automatic logic [N_IN-1:0] pick_row(input logic [N_OUT-1:0][N_IN-1:0] m,
                                               input logic [OW-1:0] o);
    logic [N_IN-1:0] r;
    r = '0;
    for (int k = 0; k < N_OUT; k++)
      if (OW'(k) == o) r = m[k];
    return r;
  endfunction

  function automatic logic [N_IN-1:0] in_mask(input logic [IW-1:0] i);
    logic [N_IN-1:0] m;
    m = '0;
    for (int k = 0; k < N_IN; k++)
      if (IW'(k) == i) m[k] = 1'b1;
    return m;
  endfunction

  xbar_op_e        op;
  logic            accept, out_ok, in_ok, row_busy, same_src, legal;
  logic [N_IN-1:0] cur_row, new_mask;

  assign op       = xbar_op_e'(cmd_op);
  assign accept   = cmd_valid && (state_q == ST_IDLE);
  assign out_ok   = cmd_out < OW'(N_OUT);
  assign in_ok    = cmd_in < IW'(N_IN);
  assign cur_row  = pick_row(xp_q, cmd_out);
  assign new_mask = in_mask(cmd_in);
  assign row_busy = |cur_row;
  assign same_src = |(cur_row & new_mask);

  always_comb begin
    unique case (op)
      OP_CONNECT: legal = out_ok && in_ok && !row_busy;
      OP_DROP:    legal = out_ok && row_busy;
      OP_MOVE:    legal = out_ok && in_ok && row_busy && !same_src;
      default:    legal = 1'b0;
    endcase
  end

  assign make_ev  = accept && legal && (op == OP_MOVE);
  assign break_ev = (state_q == ST_OVERLAP) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xp_q     <= '0;
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      mv_out_q <= '0;
      mv_new_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (legal) begin
          for (int k = 0; k < N_OUT; k++) begin
            if (OW'(k) == cmd_out) begin
              if (op == OP_DROP) xp_q[k] <= '0;
              else               xp_q[k] <= xp_q[k] | new_mask;
            end
          end
          if (op == OP_MOVE) begin
            mv_out_q <= cmd_out;
            mv_new_q <= new_mask;
            cnt_q    <= overlap_cycles;
            state_q  <= ST_OVERLAP;
          end else begin
            done_q <= 1'b1;
          end
        end else begin
          err_q <= 1'b1;
        end
      end else if (state_q == ST_OVERLAP) begin
        if (cnt_q == '0) begin
          for (int k = 0; k < N_OUT; k++)
            if (OW'(k) == mv_out_q) xp_q[k] <= mv_new_q;
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign xp_flat = xp_q;
  assign mv_row  = pick_row(xp_q, mv_out_q);
  assign busy    = (state_q == ST_OVERLAP);
  assign done    = done_q;
  assign err     = err_q;
endmodule

// File: rtl/mbb_xbar.sv
module mbb_xbar #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int DW    = 8,
  parameter int OVL_W = 4,
  localparam int IW   = $clog2(N_IN) + 1,
  localparam int OW   = $clog2(N_OUT) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic [OW-1:0]       cmd_out,
  input  logic [IW-1:0]       cmd_in,
  input  logic [OVL_W-1:0]    overlap_cycles,
  input  logic [N_IN*DW-1:0]  in_data,
  output logic [N_OUT*DW-1:0] out_data,
  output logic                busy,
  output logic                done,
  output logic                err
);
  logic [N_OUT*N_IN-1:0] xp_flat;
  logic [N_IN-1:0]       mv_row;
  logic                  make_ev, break_ev;

  mbb_xbar_seq #(
    .N_IN(N_IN), .N_OUT(N_OUT), .OVL_W(OVL_W), .IW(IW), .OW(OW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_out(cmd_out), .cmd_in(cmd_in), .overlap_cycles(overlap_cycles),
    .xp_flat(xp_flat), .mv_row(mv_row), .make_ev(make_ev), .break_ev(break_ev),
    .busy(busy), .done(done), .err(err)
  );

  assign cmd_ready = !busy;

  for (genvar o = 0; o < N_OUT; o++) begin : g_col
    mbb_xbar_col #(.N_IN(N_IN), .DW(DW)) u_col (
      .sel(xp_flat[o*N_IN +: N_IN]),
      .in_data(in_data),
      .y(out_data[o*DW +: DW])
    );
  end
endmodule

// File: rtl/mbb_xbar_chk.sv
module mbb_xbar_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  done,
  input logic                  err,
  input logic                  make_ev,
  input logic                  break_ev,
  input logic [N_IN-1:0]       mv_row,
  input logic [N_OUT*N_IN-1:0] xp_flat
);
  function automatic logic any_multi(input logic [N_OUT*N_IN-1:0] m);
    logic f;
    f = 1'b0;
    for (int o = 0; o < N_OUT; o++)
      if ($countones(m[o*N_IN +: N_IN]) > 1) f = 1'b1;
    return f;
  endfunction

  logic multi;
  assign multi = any_multi(xp_flat);

  assert_make_enters_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    make_ev |=> busy);
  assert_overlap_two_sources_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(mv_row) == 2);
  assert_break_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    break_ev |=> (!busy && done && $countones(mv_row) == 1));
  assert_busy_fall_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_err_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_single_source_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !multi);
endmodule

bind mbb_xbar mbb_xbar_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .make_ev(make_ev), .break_ev(break_ev), .mv_row(mv_row), .xp_flat(xp_flat)
);

// File: tb/mbb_xbar_test.sv
`timescale 1ns/1ps
module mbb_xbar_test;
  localparam int N_IN = 4, N_OUT = 4, DW = 8, OVL_W = 4;
  localparam int IW = $clog2(N_IN) + 1, OW = $clog2(N_OUT) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [OW-1:0] cmd_out = '0;
  logic [IW-1:0] cmd_in = '0;
  logic [OVL_W-1:0] overlap_cycles = '0;
  logic [N_IN*DW-1:0] din = '0;
  logic [N_OUT*DW-1:0] dout;
  logic busy, done, err;

  int checks = 0, errors = 0;
  int src [N_OUT];

  always #5 clk = ~clk;

  mbb_xbar #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .OVL_W(OVL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_out(cmd_out), .cmd_in(cmd_in),
    .overlap_cycles(overlap_cycles), .in_data(din), .out_data(dout),
    .busy(busy), .done(done), .err(err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lane_in(input int i);
    return int'(din[i*DW +: DW]);
  endfunction

  function automatic int lane_out(input int o);
    return int'(dout[o*DW +: DW]);
  endfunction

  function automatic int model_out(input int o);
    return (src[o] < 0) ? 0 : lane_in(src[o]);
  endfunction

  task automatic check_all(input string req);
    din = {$urandom, $urandom};
    #1;
    for (int o = 0; o < N_OUT; o++)
      chk(lane_out(o) == model_out(o), req, lane_out(o), model_out(o));
  endtask

  function automatic bit is_legal(input int op, input int o, input int i);
    if (op == 1) return (o < N_OUT) && (i < N_IN) && (src[o] < 0);
    if (op == 2) return (o < N_OUT) && (src[o] >= 0);
    if (op == 3) return (o < N_OUT) && (i < N_IN) && (src[o] >= 0) && (src[o] != i);
    return 1'b0;
  endfunction

  task automatic issue(input int op, input int o, input int i, input int ovl);
    bit lg;
    int old, k, exp;
    while (!cmd_ready) @(negedge clk);
    lg = is_legal(op, o, i);
    old = (o < N_OUT) ? src[o] : -1;
    cmd_op = op[1:0]; cmd_out = o[OW-1:0]; cmd_in = i[IW-1:0];
    overlap_cycles = ovl[OVL_W-1:0]; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (lg && op == 3) begin
      k = 0;
      while (busy && k < 40) begin
        din = {$urandom, $urandom};
        #1;
        exp = lane_in(old) | lane_in(i);
        chk(lane_out(o) == exp, "R5 overlap OR", lane_out(o), exp);
        chk(!cmd_ready, "R5 ready low while busy", int'(cmd_ready), 0);
        k++;
        @(negedge clk);
      end
      chk(k == ovl + 1, "R5 overlap length", k, ovl + 1);
      chk(done && !err && !busy, "R6 done at break", int'({busy, err, done}), 1);
      src[o] = i;
      check_all("R6 new source only");
    end else begin
      chk(done == lg, (op == 2) ? "R4 done pulse" : "R2 done pulse", int'(done), int'(lg));
      chk(err == !lg, "R7 err pulse", int'(err), int'(!lg));
      chk(!busy, "R2 no busy", int'(busy), 0);
      if (lg) src[o] = (op == 1) ? i : -1;
      check_all(lg ? ((op == 2) ? "R4 disconnect" : "R3 lane routing") : "R7 state unchanged");
      @(negedge clk);
      chk(!done && !err, "R8 pulses one cycle", int'({err, done}), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int o = 0; o < N_OUT; o++) src[o] = -1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R1 outputs zero in reset");
    chk(!busy && !done && !err, "R1 flags in reset", int'({busy, done, err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 outputs zero after reset");
    chk(!busy && !done && !err && cmd_ready, "R1 flags after reset", int'({busy, done, err}), 0);

    issue(1, 0, 1, 0);            // R2 connect
    issue(1, 1, 2, 0);            // R2 fan-out of input 2
    issue(1, 2, 2, 0);
    issue(1, 3, 2, 0);
    issue(3, 0, 3, 0);            // R5 shortest overlap
    issue(3, 1, 0, 3);            // R5 longer overlap
    issue(3, 2, 2, 1);            // R7 move to present source
    issue(1, 3, 1, 0);            // R7 connect on driven output
    issue(2, 3, 0, 0);            // R4 disconnect
    issue(2, 3, 0, 0);            // R7 disconnect idle
    issue(3, 3, 1, 2);            // R7 move on idle output
    issue(0, 0, 0, 0);            // R7 opcode none
    issue(1, 5, 0, 0);            // R7 output index out of range
    issue(1, 3, 6, 0);            // R7 input index out of range
    issue(3, 0, 4, 0);            // R7 move to out-of-range input
    issue(3, 0, 1, 15);           // R5 maximal overlap

    for (int n = 0; n < 120; n++)
      issue(int'($urandom_range(3, 0)), int'($urandom_range(N_OUT, 0)),
            int'($urandom_range(N_IN, 0)), int'($urandom_range(5, 0)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule